// File: doc/BRIEF.md
# Single-Wire Bus Master Engine

This block is the master side of a single open-drain, one-wire serial bus. It runs one operation at a time: a reset pulse that also detects whether a slave device answers, a byte write, or a byte read. A parameterized prescaler divides the system clock down to a microsecond tick. Every phase of a bus slot is a whole number of such ticks, so the same RTL can run at any clock rate.

The bus pin is modelled as an output enable plus an input. When the output enable is high, the line is pulled low. When it is low, the line is released and an external pull-up raises it. The line input passes through a two-stage synchronizer before the engine looks at it.

Software, or a sequencer above this block, starts an operation with a one-cycle `start` strobe, an operation code and a data byte. It then watches `busy` and waits for the one-cycle `done` pulse. Each time the engine stops driving the line, it holds the line released for a short settling time before it samples the line or drives it again. Bytes move least-significant bit first.

Top module: `onewire_master`

## Requirements
- R1: After reset the line is released (`lineOe`=0) and `busy`, `done`, `present` and `dataOut` are all 0. The line is never driven while `busy` is 0.
- R2: An operation starts only on `start` while idle, and its op code and `dataIn` are captured at that edge. The op codes are 2'b00 for reset/presence, 2'b01 for write byte and 2'b10 for read byte. Code 2'b11 is ignored: `busy` stays 0 and the line stays released.
- R3: A reset operation drives the line low for exactly RST_LOW_US (500) microseconds.
- R4: After the reset pulse the line is released for SETTLE_US + PRES_US (63) microseconds. At that point `present` is set to 1 if the line is low, or 0 if it is high. The engine then waits RST_TAIL_US (500) microseconds more, so a whole reset operation keeps `busy` high for 1063 microseconds.
- R5: Each write slot releases the line for LEAD_US (3) microseconds and then drives it low for LEAD_US. A 1 bit then releases the line for SLOT_US (60) microseconds. A 0 bit keeps the line low for SLOT_US more, so its low pulse lasts 63 microseconds in total. Either way each write bit occupies 69 microseconds.
- R6: Both writes and reads move the byte least-significant bit first. A read shifts each received bit in at bit 7 and shifts the register right, so after 8 slots bit 0 holds the first bit received.
- R7: Each read slot drives the line low for READ_LOW_US (1) microsecond and then releases it. The engine samples the line SETTLE_US + SAMPLE_US (13) microseconds after the release. A low level reads as 0 and a high level as 1. The slot then idles for SLOT_US, so each read bit occupies 74 microseconds, and `dataOut` holds the assembled byte at `done`.
- R8: Whenever the line goes from driven to released, it stays released for at least SETTLE_US microseconds before it is sampled or driven again.
- R9: A `start` that arrives while `busy` is 1 is ignored. It does not start a second operation and it adds no bus activity.
- R10: `done` is high for exactly one clock, in the first cycle after `busy` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin an operation |
| op | input | 2 | Operation code: 00 reset, 01 write, 10 read, 11 none |
| dataIn | input | DATA_W | Byte to write, captured at start |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle pulse when an operation finishes |
| dataOut | output | DATA_W | Byte assembled by the last read |
| present | output | 1 | A device answered the last reset pulse |
| lineOe | output | 1 | 1 pulls the bus line low, 0 releases it |
| lineIn | input | 1 | Bus line level, asynchronous |

## Verification
The bench runs a small slave model on the line. It then measures every low pulse to the clock cycle and decodes the write bits from the pulse widths. A design that sent bits MSB first would show a reversed width pattern. A design that dropped the settle phase would give each write bit a length other than 69 microseconds.

Two read runs bracket the sample point. In one, the slave holds a 0 until 12 microseconds into the slot. In the other, it holds it until 16 microseconds. A design that sampled too early or too late reads the wrong byte in one of the two runs.

Other runs cover a reset with no slave present, a start request issued in the middle of a write, and the unused op code. In each case a design that started anyway would produce an extra `done` that the scoreboard has no entry for, or extra pulses on the line.

// File: rtl/ow_pkg.sv
package ow_pkg;

  typedef enum logic [1:0] {
    OP_RESET = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_NONE  = 2'b11
  } op_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic timerLoad;
    logic shiftLoad;
    logic shiftWrite;
    logic shiftRead;
    logic presSample;
    logic bitClr;
    logic bitInc;
  } dpCtrl_t;

endpackage

// File: rtl/ow_datapath.sv
module ow_datapath #(
  parameter int CLK_PER_US = 200,
  parameter int DATA_W     = 8,
  parameter int TIMER_W    = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  ow_pkg::dpCtrl_t     ctrl,
  input  logic [TIMER_W-1:0]  timerUs,
  input  logic [DATA_W-1:0]   dataIn,
  input  logic                lineIn,
  output logic                expired,
  output logic                txBit,
  output logic                lastBit,
  output logic [DATA_W-1:0]   rxData,
  output logic                present
);
  localparam int PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [PRE_W-1:0]   preCnt;
  logic [TIMER_W-1:0] usLeft;
  logic               tick;
  logic [1:0]         syncQ;
  logic               lineSync;
  logic [DATA_W-1:0]  shiftReg;
  logic [BIT_W-1:0]   bitCnt;

  assign tick    = (preCnt == PRE_W'(CLK_PER_US - 1));
  assign expired = tick && (usLeft == TIMER_W'(1));

  // microsecond prescaler and phase timer, restarted on every load
  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      usLeft <= '0;
    end else if (ctrl.timerLoad) begin
      preCnt <= '0;
      usLeft <= timerUs;
    end else if (tick) begin
      preCnt <= '0;
      if (usLeft != '0) usLeft <= usLeft - 1'b1;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  // two-stage synchronizer, idle level is high (pulled up)
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], lineIn};
  end
  assign lineSync = syncQ[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      present  <= 1'b0;
    end else begin
      if (ctrl.shiftLoad)       shiftReg <= dataIn;
      else if (ctrl.shiftWrite) shiftReg <= {1'b0, shiftReg[DATA_W-1:1]};
      else if (ctrl.shiftRead)  shiftReg <= {lineSync, shiftReg[DATA_W-1:1]};
      if (ctrl.bitClr)          bitCnt <= '0;
      else if (ctrl.bitInc)     bitCnt <= bitCnt + 1'b1;
      if (ctrl.presSample)      present <= ~lineSync;
    end
  end

  assign txBit   = shiftReg[0];
  assign lastBit = (bitCnt == BIT_W'(DATA_W - 1));
  assign rxData  = shiftReg;

endmodule

// File: rtl/ow_control.sv
module ow_control #(
  parameter int TIMER_W     = 10,
  parameter int RST_LOW_US  = 500,
  parameter int PRES_US     = 60,
  parameter int RST_TAIL_US = 500,
  parameter int LEAD_US     = 3,
  parameter int SLOT_US     = 60,
  parameter int READ_LOW_US = 1,
  parameter int SAMPLE_US   = 10,
  parameter int SETTLE_US   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [1:0]         op,
  input  logic               expired,
  input  logic               txBit,
  input  logic               lastBit,
  output ow_pkg::dpCtrl_t    ctrl,
  output logic [TIMER_W-1:0] timerUs,
  output logic               busy,
  output logic               done,
  output logic               lineOe
);
  import ow_pkg::*;

  typedef enum logic [3:0] {
    S_IDLE, S_RST_LOW, S_RST_WAIT, S_RST_TAIL,
    S_WB_REL, S_WB_LOW, S_WB_DATA,
    S_RB_LOW, S_RB_WAIT, S_RB_REC, S_SETTLE
  } state_e;

  state_e state, retState, target, nextState;
  logic   advance, curDrive, tgtDrive;

  function automatic logic driveOf(state_e s, logic b);
    case (s)
      S_RST_LOW, S_WB_LOW, S_RB_LOW: driveOf = 1'b1;
      S_WB_DATA:                     driveOf = ~b;
      default:                       driveOf = 1'b0;
    endcase
  endfunction

  function automatic logic [TIMER_W-1:0] durOf(state_e s);
    case (s)
      S_RST_LOW:          durOf = TIMER_W'(RST_LOW_US);
      S_RST_WAIT:         durOf = TIMER_W'(PRES_US);
      S_RST_TAIL:         durOf = TIMER_W'(RST_TAIL_US);
      S_WB_REL, S_WB_LOW: durOf = TIMER_W'(LEAD_US);
      S_WB_DATA, S_RB_REC: durOf = TIMER_W'(SLOT_US);
      S_RB_LOW:           durOf = TIMER_W'(READ_LOW_US);
      S_RB_WAIT:          durOf = TIMER_W'(SAMPLE_US);
      S_SETTLE:           durOf = TIMER_W'(SETTLE_US);
      default:            durOf = '0;
    endcase
  endfunction

  assign curDrive = driveOf(state, txBit);
  assign tgtDrive = driveOf(target, txBit);

  always_comb begin
    ctrl    = '0;
    advance = 1'b0;
    target  = state;
    if (state == S_IDLE) begin
      if (start && op_e'(op) != OP_NONE) begin
        advance        = 1'b1;
        ctrl.shiftLoad = 1'b1;
        ctrl.bitClr    = 1'b1;
        case (op_e'(op))
          OP_RESET: target = S_RST_LOW;
          OP_WRITE: target = S_WB_REL;
          default:  target = S_RB_LOW;
        endcase
      end
    end else if (expired) begin
      advance = 1'b1;
      case (state)
        S_RST_LOW:  target = S_RST_WAIT;
        S_RST_WAIT: begin ctrl.presSample = 1'b1; target = S_RST_TAIL; end
        S_RST_TAIL: target = S_IDLE;
        S_WB_REL:   target = S_WB_LOW;
        S_WB_LOW:   target = S_WB_DATA;
        S_WB_DATA: begin
          ctrl.shiftWrite = 1'b1;
          ctrl.bitInc     = 1'b1;
          target          = lastBit ? S_IDLE : S_WB_REL;
        end
        S_RB_LOW:   target = S_RB_WAIT;
        S_RB_WAIT:  begin ctrl.shiftRead = 1'b1; target = S_RB_REC; end
        S_RB_REC: begin
          ctrl.bitInc = 1'b1;
          target      = lastBit ? S_IDLE : S_RB_LOW;
        end
        S_SETTLE:   target = retState;
        default:    target = S_IDLE;
      endcase
    end
    // every driven-to-released step passes through the settle phase
    nextState      = (advance && curDrive && !tgtDrive) ? S_SETTLE : target;
    ctrl.timerLoad = advance;
    timerUs        = durOf(nextState);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      retState <= S_IDLE;
      done     <= 1'b0;
    end else begin
      done <= advance && (state != S_IDLE) && (nextState == S_IDLE);
      if (advance) begin
        state <= nextState;
        if (nextState == S_SETTLE) retState <= target;
      end
    end
  end

  assign busy   = (state != S_IDLE);
  assign lineOe = curDrive;

endmodule

// File: rtl/onewire_master.sv
module onewire_master #(
  parameter int CLK_PER_US  = 200,
  parameter int DATA_W      = 8,
  parameter int RST_LOW_US  = 500,
  parameter int PRES_US     = 60,
  parameter int RST_TAIL_US = 500,
  parameter int LEAD_US     = 3,
  parameter int SLOT_US     = 60,
  parameter int READ_LOW_US = 1,
  parameter int SAMPLE_US   = 10,
  parameter int SETTLE_US   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [DATA_W-1:0] dataIn,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] dataOut,
  output logic              present,
  output logic              lineOe,
  input  logic              lineIn
);
  function automatic int maxOf(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAX_US = maxOf(maxOf(maxOf(RST_LOW_US, RST_TAIL_US), maxOf(PRES_US, SLOT_US)),
                                maxOf(maxOf(LEAD_US, SETTLE_US), maxOf(SAMPLE_US, READ_LOW_US)));
  localparam int TIMER_W    = $clog2(MAX_US + 1);
  localparam int MAX_LOW_US = maxOf(RST_LOW_US, maxOf(LEAD_US + SLOT_US, READ_LOW_US));

  ow_pkg::dpCtrl_t    ctrl;
  logic [TIMER_W-1:0] timerUs;
  logic               expired, txBit, lastBit;

  ow_control #(
    .TIMER_W(TIMER_W), .RST_LOW_US(RST_LOW_US), .PRES_US(PRES_US),
    .RST_TAIL_US(RST_TAIL_US), .LEAD_US(LEAD_US), .SLOT_US(SLOT_US),
    .READ_LOW_US(READ_LOW_US), .SAMPLE_US(SAMPLE_US), .SETTLE_US(SETTLE_US)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .op(op), .expired(expired),
    .txBit(txBit), .lastBit(lastBit), .ctrl(ctrl), .timerUs(timerUs),
    .busy(busy), .done(done), .lineOe(lineOe)
  );

  ow_datapath #(
    .CLK_PER_US(CLK_PER_US), .DATA_W(DATA_W), .TIMER_W(TIMER_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .timerUs(timerUs), .dataIn(dataIn),
    .lineIn(lineIn), .expired(expired), .txBit(txBit), .lastBit(lastBit),
    .rxData(dataOut), .present(present)
  );

endmodule

// File: rtl/ow_checker.sv
module ow_checker #(
  parameter int SETTLE_CYC  = 600,
  parameter int MAX_LOW_CYC = 100000
) (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic [1:0] op,
  input logic       busy,
  input logic       done,
  input logic       lineOe
);
  int relCyc;
  int lowCyc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      relCyc <= SETTLE_CYC;
      lowCyc <= 0;
    end else begin
      if (lineOe)                  relCyc <= 0;
      else if (relCyc < SETTLE_CYC) relCyc <= relCyc + 1;
      if (lineOe) lowCyc <= lowCyc + 1;
      else        lowCyc <= 0;
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !lineOe);                                              // R1
  AST_NONE_OP_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && op == 2'b11) |=> !busy);                      // R2
  AST_VALID_OP_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && op != 2'b11) |=> busy);                       // R2
  AST_LOW_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    lineOe |-> lowCyc < MAX_LOW_CYC);                                // R3
  AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lineOe) |-> relCyc >= SETTLE_CYC);                         // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);                                                 // R10
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));                                // R10

endmodule

bind onewire_master ow_checker #(
  .SETTLE_CYC(SETTLE_US * CLK_PER_US),
  .MAX_LOW_CYC(MAX_LOW_US * CLK_PER_US)
) uChk (
  .clk(clk), .rstN(rstN), .start(start), .op(op),
  .busy(busy), .done(done), .lineOe(lineOe)
);

// File: tb/tb_onewire_master.sv
module tb_onewire_master;
  localparam int C = 4;  // clocks per microsecond for a short run

  typedef struct {
    logic [1:0] op;
    logic [7:0] expD;
    logic       expP;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [1:0] op = 2'b00;
  logic [7:0] dataIn = 8'h00;
  logic busy, done, present, lineOe, lineIn;
  logic [7:0] dataOut;
  logic devLow = 1'b0;

  int errors = 0;
  int checks = 0;
  item_t sbQ[$];
  int pulseQ[$];
  int lowCnt = 0;
  bit finished = 0;

  // slave model controls
  bit devPresent = 0;
  bit readMode = 0;
  logic [7:0] rdByte = 8'h00;
  int holdCyc = 120;

  always #2.5 clk = ~clk;

  assign lineIn = ~(lineOe | devLow);

  onewire_master #(.CLK_PER_US(C)) dut (
    .clk(clk), .rstN(rstN), .start(start), .op(op), .dataIn(dataIn),
    .busy(busy), .done(done), .dataOut(dataOut), .present(present),
    .lineOe(lineOe), .lineIn(lineIn)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slave device model
  logic prevOe = 1'b0;
  int lowRun = 0, sinceRel = 100000, sinceSlot = 100000, rdIdx = 0;
  bit presArmed = 0;
  logic curBit = 1'b1;
  always @(posedge clk) begin
    sinceRel++;
    sinceSlot++;
    if (lineOe) begin
      if (!prevOe) begin
        sinceSlot = 0;
        lowRun = 0;
        if (readMode) begin
          curBit = rdByte[rdIdx % 8];
          rdIdx++;
        end
      end
      lowRun++;
    end else if (prevOe) begin
      presArmed = (lowRun >= 480 * C);
      sinceRel = 0;
    end
    prevOe <= lineOe;
    devLow <= (devPresent && presArmed && sinceRel >= 15 * C && sinceRel < 75 * C) ||
              (readMode && !curBit && sinceSlot < holdCyc);
  end

  // pulse-width monitor
  always @(negedge clk) begin
    if (lineOe) lowCnt++;
    else if (lowCnt > 0) begin
      pulseQ.push_back(lowCnt);
      lowCnt = 0;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && done) begin
      if (sbQ.size() == 0) check(0, "R9 unexpected done", 1, 0);
      else begin
        item_t it;
        it = sbQ.pop_front();
        if (it.op == 2'b00) check(present == it.expP, "R4 presence", present, it.expP);
        else if (it.op == 2'b10) check(dataOut == it.expD, "R7 R6 read byte", dataOut, it.expD);
      end
    end
  end

  task automatic runOp(input logic [1:0] o, input logic [7:0] d, input logic [7:0] expD,
                       input logic expP, output int busyCyc);
    item_t it;
    it.op = o; it.expD = expD; it.expP = expP;
    sbQ.push_back(it);
    pulseQ.delete();
    rdIdx = 0;
    @(negedge clk);
    start = 1'b1; op = o; dataIn = d;
    @(negedge clk);
    start = 1'b0;
    busyCyc = 0;
    while (busy) begin
      busyCyc++;
      @(negedge clk);
    end
    check(done == 1'b1, "R10 done at busy fall", done, 1);
    @(negedge clk);
    check(done == 1'b0, "R10 done one cycle", done, 0);
  endtask

  task automatic checkWrite(input logic [7:0] d, input int busyCyc);
    check(busyCyc == 69 * 8 * C, "R5 write length", busyCyc, 69 * 8 * C);
    check(pulseQ.size() == 8, "R5 write pulse count", pulseQ.size(), 8);
    for (int i = 0; i < 8 && i < pulseQ.size(); i++) begin
      int w;
      w = d[i] ? 3 * C : 63 * C;
      check(pulseQ[i] == w, "R5 R6 write bit width", pulseQ[i], w);
    end
  endtask

  initial begin
    int bc;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!lineOe && !busy && !done && !present && dataOut == 8'h00, "R1 reset state",
          {lineOe, busy, done, present}, 0);

    // reset with a device present
    devPresent = 1;
    runOp(2'b00, 8'h00, 8'h00, 1'b1, bc);
    check(bc == 1063 * C, "R4 reset length", bc, 1063 * C);
    check(pulseQ.size() == 1 && pulseQ[0] == 500 * C, "R3 reset low width",
          pulseQ.size() > 0 ? pulseQ[0] : -1, 500 * C);

    // reset with no device
    devPresent = 0;
    runOp(2'b00, 8'h00, 8'h00, 1'b0, bc);
    check(present == 1'b0, "R4 no device", present, 0);

    // writes, LSB first
    runOp(2'b01, 8'hA5, 8'h00, 1'b0, bc);
    checkWrite(8'hA5, bc);
    runOp(2'b01, 8'h3C, 8'h00, 1'b0, bc);
    checkWrite(8'h3C, bc);

    // reads
    readMode = 1;
    holdCyc = 30 * C;
    rdByte = 8'h96;
    runOp(2'b10, 8'h00, 8'h96, 1'b0, bc);
    check(bc == 74 * 8 * C, "R7 read length", bc, 74 * 8 * C);
    check(pulseQ.size() == 8 && pulseQ[0] == 1 * C, "R7 read low width",
          pulseQ.size() > 0 ? pulseQ[0] : -1, 1 * C);
    rdByte = 8'h5A;
    runOp(2'b10, 8'hFF, 8'h5A, 1'b0, bc);
    // sample point boundaries: slave holds 0 until 12 us, then 16 us
    rdByte = 8'h00;
    holdCyc = 12 * C;
    runOp(2'b10, 8'h00, 8'hFF, 1'b0, bc);
    holdCyc = 16 * C;
    runOp(2'b10, 8'hFF, 8'h00, 1'b0, bc);
    readMode = 0;

    // R9: start while busy is ignored
    begin
      item_t it;
      it.op = 2'b01; it.expD = 8'h00; it.expP = 1'b0;
      sbQ.push_back(it);
      pulseQ.delete();
      @(negedge clk);
      start = 1'b1; op = 2'b01; dataIn = 8'h00;
      @(negedge clk);
      start = 1'b0;
      repeat (100) @(negedge clk);
      start = 1'b1; op = 2'b00;
      @(negedge clk);
      start = 1'b0;
      while (busy) @(negedge clk);
      repeat (3000) @(negedge clk);
      check(!busy, "R9 no second op", busy, 0);
      check(pulseQ.size() == 8, "R9 pulse count", pulseQ.size(), 8);
    end

    // R2: op code 11 ignored
    pulseQ.delete();
    @(negedge clk);
    start = 1'b1; op = 2'b11; dataIn = 8'hFF;
    @(negedge clk);
    start = 1'b0;
    check(!busy, "R2 op 11 ignored busy", busy, 0);
    repeat (50) @(negedge clk);
    check(!busy && !lineOe && pulseQ.size() == 0, "R2 op 11 no activity", pulseQ.size(), 0);
    check(sbQ.size() == 0, "R9 scoreboard drained", sbQ.size(), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule